// File: doc/BRIEF.md
# Shadow Page Remapping Unit

This unit sits on the memory side of the system bus and adds a second translation step. Processors place physical addresses on the bus. Some of those addresses fall in a window of physical space that has no memory behind it: the shadow window. The unit checks each incoming address against that window. A shadow address has its base-page frame replaced by a real frame, taken from a local page table, and keeps its in-page offset. Every other address leaves the unit unchanged.

Because each shadow page is looked up on its own, an aligned run of shadow pages can stand for real pages that are scattered through memory. The operating system can map that run as one large page in the processor's TLB. The TLB never sees the second step.

The window is set by a base frame and a frame mask, both held steady on input ports. A write port loads table entries. Each entry holds a real frame and a live bit. An access that hits a shadow page whose entry is not live gives an error response instead of an address. Requests and responses use a valid/ready handshake, with one register stage between them.

Top module: `shadow_remap`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every table entry is not live. Any access inside the window then returns out_err = 1.
- R2: A request whose frame is outside the window returns out_addr equal to in_addr with out_err = 0.
- R3: A request inside the window whose entry is live returns out_addr = {entry frame, in_addr[11:0]} with out_err = 0. The offset is the low OFS_W bits, which are 12 by default.
- R4: A request inside the window whose entry is not live returns out_err = 1 with out_addr = 0.
- R5: A frame is inside the window when two conditions both hold. First, (frame XOR win_base) AND win_mask is zero. Second, frame − win_base is below 2^IDX_W. That difference selects the table entry. A frame that matches the mask but lies 2^IDX_W or more pages above win_base passes through unchanged.
- R6: A request accepted at a rising edge (in_valid and in_ready both 1) has its result on the outputs, with out_valid = 1, right after that edge. When no request is accepted and the current result is consumed, out_valid is 0 after the edge.
- R7: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_addr and out_err hold their values.
- R8: A cycle with cfg_we = 1 writes cfg_frame and cfg_live into entry cfg_idx. A later write to the same entry replaces it, and writing cfg_live = 0 makes the entry not live again. A request accepted in a later cycle sees the new contents.
- R9: With win_base = 0x80200, win_mask = 0xFFF00 and entry 0x40 holding live frame 0x40138, the address 0x80240080 becomes 0x40138080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_base | input | ADDR_W-OFS_W | First frame of the shadow window |
| win_mask | input | ADDR_W-OFS_W | Frame bits compared against win_base |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_frame | input | ADDR_W-OFS_W | Real frame for the entry |
| cfg_live | input | 1 | Live bit for the entry |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_addr | input | ADDR_W | Bus address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | ADDR_W | Translated or passed-through address |
| out_err | output | 1 | Shadow page without a live entry |

## Verification
The bench uses the default parameters: 32-bit addresses, a 12-bit offset and a table of 256 entries. With these values the whole table can be reached. The first check sweeps every entry to confirm that it starts empty. A later phase loads a random set of entries and then sends a random mix of in-window and out-of-window addresses. Setting the mask wider than the table makes the upper bound of R5 visible, and the worked address of R9 is sent as a directed case.

// File: rtl/shadow_remap.sv
module shadow_remap #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-OFS_W-1:0] win_base,
  input  logic [ADDR_W-OFS_W-1:0] win_mask,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [ADDR_W-OFS_W-1:0] cfg_frame,
  input  logic                    cfg_live,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic                    out_err
);
  localparam int FRM_W = ADDR_W - OFS_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [FRM_W-1:0] map_frame [DEPTH];
  logic [DEPTH-1:0] map_live;

  logic [FRM_W-1:0] in_frm, rel;
  logic [IDX_W-1:0] idx;
  logic             in_win, take;

  assign in_frm   = in_addr[ADDR_W-1:OFS_W];
  assign rel      = in_frm - win_base;
  assign idx      = rel[IDX_W-1:0];
  assign in_win   = (((in_frm ^ win_base) & win_mask) == '0) && (rel[FRM_W-1:IDX_W] == '0);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (cfg_we) map_frame[cfg_idx] <= cfg_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_live <= '0;
    else if (cfg_we) map_live[cfg_idx] <= cfg_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      if (!in_win) begin
        out_addr <= in_addr;
        out_err  <= 1'b0;
      end else if (map_live[idx]) begin
        out_addr <= {map_frame[idx], in_addr[OFS_W-1:0]};
        out_err  <= 1'b0;
      end else begin
        out_addr <= '0;
        out_err  <= 1'b1;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));

  // R6
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && (!out_valid || out_ready)) |=> !out_valid);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == '0));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_win) |=> (out_addr == $past(in_addr) && !out_err));
endmodule

// File: tb/test_shadow_remap.sv
module test_shadow_remap;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int IDX_W  = 8;
  localparam int FRM_W  = ADDR_W - OFS_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FRM_W-1:0] win_base = 20'h80200;
  logic [FRM_W-1:0] win_mask = 20'hFFF00;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [FRM_W-1:0] cfg_frame = '0;
  logic cfg_live = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [ADDR_W-1:0] out_addr;
  logic out_err;

  int checks = 0;
  int errors = 0;
  logic [FRM_W-1:0] m_frame [DEPTH];
  logic [DEPTH-1:0] m_live = '0;

  always #2.5 clk = ~clk;

  shadow_remap #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) i_shadow_remap (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .win_mask(win_mask),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_frame(cfg_frame), .cfg_live(cfg_live),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_err(out_err));

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [ADDR_W-1:0] a);
    logic [FRM_W-1:0] f, r;
    f = a[ADDR_W-1:OFS_W];
    r = f - win_base;
    if ((((f ^ win_base) & win_mask) != '0) || (r[FRM_W-1:IDX_W] != '0)) return {1'b0, a};
    if (m_live[r[IDX_W-1:0]]) return {1'b0, m_frame[r[IDX_W-1:0]], a[OFS_W-1:0]};
    return {1'b1, 32'h0};
  endfunction

  task automatic cfg(input logic [IDX_W-1:0] i, input logic [FRM_W-1:0] f, input logic lv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_frame = f; cfg_live = lv;
    @(negedge clk);
    cfg_we = 1'b0;
    m_frame[i] = f;
    m_live[i] = lv;
  endtask

  task automatic xfer(input logic [ADDR_W-1:0] a, input string tag);
    logic [32:0] e;
    e = model(a);
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    check(out_valid === 1'b0, "R6 idle before accept", {1'b0, out_valid, 32'h0}, 34'h0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_err === e[32] && out_addr === e[31:0], tag,
          {out_valid, out_err, out_addr}, {1'b1, e});
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [32:0] e1, e2;
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 reset outputs",
          {out_valid, in_ready, 32'h0}, {2'b01, 32'h0});
    for (int i = 0; i < DEPTH; i++) xfer({win_base + FRM_W'(i), 12'h5A5}, "R1 entry empty");

    cfg(8'h40, 20'h40138, 1'b1);
    xfer(32'h80240080, "R9 worked example");
    cfg(8'h41, 20'h04012, 1'b1);
    cfg(8'h42, 20'h20285, 1'b1);
    cfg(8'h43, 20'h06155, 1'b1);
    xfer(32'h80241FFF, "R3 scattered page 1");
    xfer(32'h80242000, "R3 scattered page 2");
    xfer(32'h80243ABC, "R3 scattered page 3");
    xfer(32'h12345678, "R2 passthrough");
    xfer(32'h802FF000, "R4 last entry not live");
    cfg(8'h42, 20'h0BEEF, 1'b1);
    xfer(32'h80242123, "R8 overwrite");
    cfg(8'h42, 20'h0BEEF, 1'b0);
    xfer(32'h80242123, "R8 invalidate");

    win_mask = 20'hFFE00;
    xfer(32'h80300444, "R5 above table passes through");
    xfer(32'h801FF444, "R5 below base passes through");
    win_mask = 20'hFFF00;

    @(negedge clk);
    out_ready = 1'b0;
    e1 = model(32'h80240010);
    e2 = model(32'h77777777);
    in_addr = 32'h80240010; in_valid = 1'b1;
    @(negedge clk);
    in_addr = 32'h77777777;
    for (int k = 0; k < 3; k++) begin
      check(out_valid === 1'b1 && in_ready === 1'b0 && out_addr === e1[31:0] && out_err === e1[32],
            "R7 stall holds", {in_ready, out_err, out_addr}, {1'b0, e1});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_addr === e2[31:0] && out_err === e2[32], "R7 release",
          {out_valid, out_err, out_addr}, {1'b1, e2});
    @(negedge clk);
    check(out_valid === 1'b0, "R6 drains", {1'b0, out_valid, 32'h0}, 34'h0);

    for (int n = 0; n < 80; n++)
      cfg(IDX_W'($urandom), FRM_W'($urandom), 1'($urandom));
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 3 != 0)
        xfer({win_base + FRM_W'($urandom % DEPTH), 12'($urandom)}, "R3 random window");
      else
        xfer($urandom, "R2 random address");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule